// File: doc/BRIEF.md
# Integer ALU with Registered Status Flags

This unit is the 32-bit integer arithmetic and shift stage of a DSP-style datapath. Each cycle it takes two operands, an operation code and a shift count, and produces a result combinationally. When the operation is marked valid, a set of status flags is captured on the next clock edge. The flags are zero, negative, carry, overflow, and a sticky overflow that accumulates arithmetic overflows until software or the sequencer clears it.

The supported operations are add, subtract, signed minimum and maximum, three shifts (arithmetic right, logical right, left) and a combined add followed by a short left shift. The carry flag is rewritten only when the carry-update input allows it, and a sticky-clear strobe resets the accumulated overflow. This strobe is honoured whether or not an operation is valid in the same cycle.

Top module: `int_alu_status`

## Requirements
- R1: After a valid operation with a defined code (0 to 7), the zero flag is set exactly when the 32-bit result is zero, and the negative flag equals result bit 31.
- R2: Code 0 adds. Overflow is set when both operands have the same sign and the sum has the other sign. With carry update enabled, carry takes the unsigned carry-out of bit 31.
- R3: Code 1 computes opA minus opB. Overflow is set when the operand signs differ and the result sign differs from opA's sign. With carry update enabled, carry is set when opB is less than or equal to opA as unsigned values, meaning no borrow.
- R4: The carry flag holds its value when carry update is low, and for every operation other than add and subtract.
- R5: Overflow from add, subtract or add-then-shift sets the sticky flag, which then stays set until a sticky-clear strobe.
- R6: A sticky-clear strobe forces the sticky flag to 0 on the next edge, even when an overflow occurs in the same cycle. The non-sticky overflow flag still reports that overflow.
- R7: Code 2 returns the signed minimum and code 3 the signed maximum of the operands. Both clear overflow.
- R8: Code 4 is an arithmetic right shift of opA, code 5 a logical right shift and code 6 a left shift, each by shiftCnt. Counts above 32 act as 32: an arithmetic shift by 32 gives 32 copies of the sign bit, and a logical shift of either direction by 32 gives zero. All shifts clear overflow.
- R9: Code 7 adds the operands and shifts the sum left by shiftCnt[1:0] places, with 3 treated as 2. Before each one-place step, an overflow is noted if bits 31:30 are 01 or 10. The overflow flag is the OR of these checks, and it also sets the sticky flag.
- R10: With opValid low, the zero, negative, carry and overflow flags keep their values, while the result output still follows the inputs.
- R11: Codes 8 to 15 drive the result to zero and leave all flags unchanged.
- R12: After reset all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation valid; enables the flag update |
| opCode | input | 4 | Operation code |
| opA | input | 32 | First operand (minuend, shifted value) |
| opB | input | 32 | Second operand |
| shiftCnt | input | 6 | Shift count |
| carryEn | input | 1 | Allow add and subtract to update carry |
| stickyClr | input | 1 | Clear the sticky overflow flag |
| result | output | 32 | Combinational result |
| flagZero | output | 1 | Result was zero |
| flagNeg | output | 1 | Result bit 31 |
| flagCarry | output | 1 | Carry / no-borrow |
| flagOvf | output | 1 | Overflow of the last operation |
| flagSticky | output | 1 | Accumulated overflow |

## Verification
The hardest case to reach is the add-then-shift overflow that appears only on the second shift step. The sum's top two bits agree, but bits 30:29 do not. The stimulus builds sums of 0x20000000 and 0x60000000 and applies them with counts of 1, 2 and 3, so that the first-step check and the second-step check are each exercised on their own. It also collides a sticky clear with an overflowing add in the same cycle, which shows the priority of the clear and the independence of the plain overflow flag.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_MIN    = 4'd2,
    OP_MAX    = 4'd3,
    OP_ASR    = 4'd4,
    OP_LSR    = 4'd5,
    OP_LSL    = 4'd6,
    OP_ADDSHL = 4'd7
  } aluOp_e;

  localparam logic [3:0] LAST_DEFINED_OP = 4'd7;

  // strobes from control to datapath
  typedef struct packed {
    aluOp_e opSel;
    logic   opKnown;
  } aluDpCtrl_t;

  // strobes from control to the flag register
  typedef struct packed {
    logic loadNz;
    logic loadOvf;
    logic loadCarry;
    logic ovfToSticky;
  } aluFlagCtrl_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic         opValid,
  input  logic [3:0]   opCode,
  input  logic         carryEn,
  output aluDpCtrl_t   dpCtrl,
  output aluFlagCtrl_t flagCtrl
);

  logic   known;
  aluOp_e op;

  assign known = (opCode <= LAST_DEFINED_OP);
  assign op    = aluOp_e'(opCode);

  always_comb begin
    dpCtrl.opSel   = op;
    dpCtrl.opKnown = known;

    flagCtrl.loadNz      = opValid && known;
    flagCtrl.loadOvf     = opValid && known;
    flagCtrl.loadCarry   = opValid && known && carryEn &&
                           ((op == OP_ADD) || (op == OP_SUB));
    flagCtrl.ovfToSticky = opValid && known &&
                           ((op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDSHL));
  end

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 6,
  parameter int MAX_ADDSHL = 2
) (
  input  aluDpCtrl_t          dpCtrl,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [CNT_W-1:0]    shiftCnt,
  output logic [DATA_W-1:0]   result,
  output logic                ovfRaw,
  output logic                carryRaw
);

  localparam int ASL_CW = (MAX_ADDSHL < 2) ? 1 : $clog2(MAX_ADDSHL + 1);
  localparam logic [CNT_W-1:0]  CLAMP_CNT = CNT_W'(DATA_W);
  localparam logic [ASL_CW-1:0] ASL_LIMIT = ASL_CW'(MAX_ADDSHL);

  // add / subtract
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] diffVal;
  logic              addOvf;
  logic              subOvf;
  logic              subNoBorrow;

  assign sumWide     = {1'b0, opA} + {1'b0, opB};
  assign sumVal      = sumWide[DATA_W-1:0];
  assign diffVal     = opA - opB;
  assign addOvf      = (opA[DATA_W-1] == opB[DATA_W-1]) &&
                       (sumVal[DATA_W-1] != opA[DATA_W-1]);
  assign subOvf      = (opA[DATA_W-1] != opB[DATA_W-1]) &&
                       (diffVal[DATA_W-1] != opA[DATA_W-1]);
  assign subNoBorrow = (opB <= opA);

  // signed compare
  logic              aGreater;
  logic [DATA_W-1:0] minVal;
  logic [DATA_W-1:0] maxVal;

  assign aGreater = ($signed(opA) > $signed(opB));
  assign minVal   = aGreater ? opB : opA;
  assign maxVal   = aGreater ? opA : opB;

  // clamped shifts
  logic [CNT_W-1:0]  effCnt;
  logic [DATA_W-1:0] asrVal;
  logic [DATA_W-1:0] lsrVal;
  logic [DATA_W-1:0] lslVal;

  assign effCnt = (shiftCnt > CLAMP_CNT) ? CLAMP_CNT : shiftCnt;
  assign asrVal = DATA_W'($signed(opA) >>> effCnt);
  assign lsrVal = opA >> effCnt;
  assign lslVal = opA << effCnt;

  // add then short left shift, one stage per possible step
  logic [ASL_CW-1:0] aslCnt;
  logic [DATA_W-1:0] aslStage [MAX_ADDSHL+1];
  logic [MAX_ADDSHL-1:0] stepOvf;
  logic [MAX_ADDSHL-1:0] stepUsed;
  logic              aslOvf;
  logic [DATA_W-1:0] aslVal;

  assign aslCnt      = (shiftCnt[ASL_CW-1:0] > ASL_LIMIT) ? ASL_LIMIT : shiftCnt[ASL_CW-1:0];
  assign aslStage[0] = sumVal;

  for (genvar k = 0; k < MAX_ADDSHL; k++) begin : g_aslStep
    assign stepOvf[k]    = aslStage[k][DATA_W-1] ^ aslStage[k][DATA_W-2];
    assign stepUsed[k]   = (32'(aslCnt) > k);
    assign aslStage[k+1] = {aslStage[k][DATA_W-2:0], 1'b0};
  end

  assign aslOvf = |(stepOvf & stepUsed);

  always_comb begin
    aslVal = aslStage[0];
    for (int k = 1; k <= MAX_ADDSHL; k++) begin
      if (32'(aslCnt) == k) aslVal = aslStage[k];
    end
  end

  // output selection
  always_comb begin
    result   = '0;
    ovfRaw   = 1'b0;
    carryRaw = 1'b0;
    if (dpCtrl.opKnown) begin
      unique case (dpCtrl.opSel)
        OP_ADD: begin
          result   = sumVal;
          ovfRaw   = addOvf;
          carryRaw = sumWide[DATA_W];
        end
        OP_SUB: begin
          result   = diffVal;
          ovfRaw   = subOvf;
          carryRaw = subNoBorrow;
        end
        OP_MIN:    result = minVal;
        OP_MAX:    result = maxVal;
        OP_ASR:    result = asrVal;
        OP_LSR:    result = lsrVal;
        OP_LSL:    result = lslVal;
        OP_ADDSHL: begin
          result = aslVal;
          ovfRaw = aslOvf;
        end
        default:   result = '0;
      endcase
    end
  end

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import int_alu_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  aluFlagCtrl_t flagCtrl,
  input  logic         resZero,
  input  logic         resMsb,
  input  logic         ovfRaw,
  input  logic         carryRaw,
  input  logic         stickyClr,
  output logic         flagZero,
  output logic         flagNeg,
  output logic         flagCarry,
  output logic         flagOvf,
  output logic         flagSticky
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagZero   <= 1'b0;
      flagNeg    <= 1'b0;
      flagCarry  <= 1'b0;
      flagOvf    <= 1'b0;
      flagSticky <= 1'b0;
    end else begin
      if (flagCtrl.loadNz) begin
        flagZero <= resZero;
        flagNeg  <= resMsb;
      end
      if (flagCtrl.loadOvf)   flagOvf   <= ovfRaw;
      if (flagCtrl.loadCarry) flagCarry <= carryRaw;
      if (stickyClr)
        flagSticky <= 1'b0;
      else if (flagCtrl.ovfToSticky && ovfRaw)
        flagSticky <= 1'b1;
    end
  end

endmodule

// File: rtl/int_alu_status.sv
module int_alu_status
  import int_alu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 6,
  parameter int MAX_ADDSHL = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [CNT_W-1:0]  shiftCnt,
  input  logic              carryEn,
  input  logic              stickyClr,
  output logic [DATA_W-1:0] result,
  output logic              flagZero,
  output logic              flagNeg,
  output logic              flagCarry,
  output logic              flagOvf,
  output logic              flagSticky
);

  aluDpCtrl_t   dpCtrl;
  aluFlagCtrl_t flagCtrl;
  logic         ovfRaw;
  logic         carryRaw;

  int_alu_ctrl u_ctrl (
    .opValid  (opValid),
    .opCode   (opCode),
    .carryEn  (carryEn),
    .dpCtrl   (dpCtrl),
    .flagCtrl (flagCtrl)
  );

  int_alu_datapath #(
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .MAX_ADDSHL (MAX_ADDSHL)
  ) u_dp (
    .dpCtrl   (dpCtrl),
    .opA      (opA),
    .opB      (opB),
    .shiftCnt (shiftCnt),
    .result   (result),
    .ovfRaw   (ovfRaw),
    .carryRaw (carryRaw)
  );

  int_alu_flags u_flags (
    .clk        (clk),
    .rstN       (rstN),
    .flagCtrl   (flagCtrl),
    .resZero    (result == '0),
    .resMsb     (result[DATA_W-1]),
    .ovfRaw     (ovfRaw),
    .carryRaw   (carryRaw),
    .stickyClr  (stickyClr),
    .flagZero   (flagZero),
    .flagNeg    (flagNeg),
    .flagCarry  (flagCarry),
    .flagOvf    (flagOvf),
    .flagSticky (flagSticky)
  );

endmodule

// File: rtl/int_alu_status_chk.sv
module int_alu_status_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic              carryEn,
  input logic              stickyClr,
  input logic [DATA_W-1:0] result,
  input logic              flagZero,
  input logic              flagNeg,
  input logic              flagCarry,
  input logic              flagOvf,
  input logic              flagSticky
);

  // R1
  a_r1_zero_tracks_result: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode <= 4'd7) |=> (flagZero == ($past(result) == '0)));

  // R1
  a_r1_neg_tracks_result: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode <= 4'd7) |=> (flagNeg == $past(result[DATA_W-1])));

  // R4
  a_r4_carry_held: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || !carryEn || opCode > 4'd1) |=> $stable(flagCarry));

  // R5
  a_r5_sticky_holds: assert property (@(posedge clk) disable iff (!rstN)
    (flagSticky && !stickyClr) |=> flagSticky);

  // R5
  a_r5_ovf_sets_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !stickyClr && (opCode <= 4'd1 || opCode == 4'd7)) |=> (!flagOvf || flagSticky));

  // R6
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    stickyClr |=> !flagSticky);

  // R7 and R8
  a_r7_compare_shift_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode >= 4'd2 && opCode <= 4'd6) |=> !flagOvf);

  // R10
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable({flagZero, flagNeg, flagCarry, flagOvf}));

  // R11
  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (opCode > 4'd7) |-> (result == '0));

endmodule

bind int_alu_status int_alu_status_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_int_alu_status.sv
module tb_int_alu_status;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  flg;   // {zero, neg, carry, ovf, sticky}
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [5:0]  shiftCnt = '0;
  logic        carryEn = 1'b0;
  logic        stickyClr = 1'b0;
  logic [31:0] result;
  logic        flagZero, flagNeg, flagCarry, flagOvf, flagSticky;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  expItem_t sbq[$];

  // reference state of the flags
  logic mZ = 1'b0, mN = 1'b0, mC = 1'b0, mV = 1'b0, mS = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  int_alu_status dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .shiftCnt(shiftCnt), .carryEn(carryEn),
    .stickyClr(stickyClr), .result(result), .flagZero(flagZero),
    .flagNeg(flagNeg), .flagCarry(flagCarry), .flagOvf(flagOvf),
    .flagSticky(flagSticky)
  );

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [5:0] cnt, input logic cEn, input logic vld,
                       input logic clr, input string tag);
    logic [31:0] r;
    logic [32:0] w;
    logic        v, c, arith;
    int          n;
    expItem_t    it;
    @(negedge clk);
    opCode = op; opA = a; opB = b; shiftCnt = cnt;
    carryEn = cEn; opValid = vld; stickyClr = clr;
    r = 32'h0; v = 1'b0; c = mC; arith = 1'b0;
    n = (cnt > 6'd32) ? 32 : int'(cnt);
    case (op)
      4'd0: begin
        w = {1'b0, a} + {1'b0, b}; r = w[31:0]; arith = 1'b1;
        v = (a[31] ~^ b[31]) & (r[31] ^ a[31]);
        if (cEn) c = w[32];
      end
      4'd1: begin
        w = {1'b0, a} - {1'b0, b}; r = w[31:0]; arith = 1'b1;
        v = (a[31] ^ b[31]) & (r[31] ^ a[31]);
        if (cEn) c = ~w[32];
      end
      4'd2: r = ($signed(a) < $signed(b)) ? a : b;
      4'd3: r = ($signed(a) < $signed(b)) ? b : a;
      4'd4: begin r = a; for (int i = 0; i < n; i++) r = {r[31], r[31:1]}; end
      4'd5: begin r = a; for (int i = 0; i < n; i++) r = {1'b0, r[31:1]}; end
      4'd6: begin r = a; for (int i = 0; i < n; i++) r = {r[30:0], 1'b0}; end
      4'd7: begin
        r = a + b; arith = 1'b1;
        n = (cnt[1:0] == 2'd3) ? 2 : int'(cnt[1:0]);
        for (int i = 0; i < n; i++) begin
          if (r[31] != r[30]) v = 1'b1;
          r = {r[30:0], 1'b0};
        end
      end
      default: r = 32'h0;
    endcase
    if (vld && op <= 4'd7) begin
      mZ = (r == 32'h0); mN = r[31]; mV = v; mC = c;
      if (arith && v) mS = 1'b1;
    end
    if (clr) mS = 1'b0;
    it.res = r; it.flg = {mZ, mN, mC, mV, mS}; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: result and flags of the item driven in the preceding half cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        expItem_t it;
        it = sbq.pop_front();
        total++;
        if (result !== it.res || {flagZero, flagNeg, flagCarry, flagOvf, flagSticky} !== it.flg) begin
          bad++;
          $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b", it.tag,
                   result, {flagZero, flagNeg, flagCarry, flagOvf, flagSticky}, it.res, it.flg);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: finished=0 expected finished=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if ({flagZero, flagNeg, flagCarry, flagOvf, flagSticky} !== 5'b0) begin
      bad++;
      $display("FAIL R12: flags=%b expected flags=00000",
               {flagZero, flagNeg, flagCarry, flagOvf, flagSticky});
    end
    rstN = 1'b1;

    drive(4'd0, 32'd5, 32'd7, 6'd0, 1'b1, 1'b1, 1'b0, "R2 add small");
    drive(4'd0, 32'hFFFF_FFFF, 32'd1, 6'd0, 1'b1, 1'b1, 1'b0, "R1 R2 add wraps to zero with carry");
    drive(4'd0, 32'h7FFF_FFFF, 32'd1, 6'd0, 1'b1, 1'b1, 1'b0, "R2 R5 add overflow");
    drive(4'd1, 32'd3, 32'd2, 6'd0, 1'b0, 1'b1, 1'b0, "R4 R5 sub carry held sticky held");
    drive(4'd1, 32'd5, 32'd5, 6'd0, 1'b1, 1'b1, 1'b0, "R3 sub equal no borrow");
    drive(4'd1, 32'd3, 32'd5, 6'd0, 1'b1, 1'b1, 1'b0, "R3 sub borrow negative");
    drive(4'd1, 32'h8000_0000, 32'd1, 6'd0, 1'b1, 1'b1, 1'b0, "R3 sub overflow");
    drive(4'd0, 32'd0, 32'd0, 6'd0, 1'b0, 1'b0, 1'b1, "R6 R10 clear while idle");
    drive(4'd0, 32'h8000_0000, 32'h8000_0000, 6'd0, 1'b0, 1'b1, 1'b1, "R6 clear beats overflow");
    drive(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 6'd0, 1'b1, 1'b0, 1'b0, "R10 idle flags held result live");
    drive(4'd2, 32'hFFFF_FFFF, 32'd1, 6'd0, 1'b1, 1'b1, 1'b0, "R7 signed min");
    drive(4'd3, 32'hFFFF_FFFF, 32'd1, 6'd0, 1'b1, 1'b1, 1'b0, "R7 signed max");
    drive(4'd0, 32'h7FFF_FFFF, 32'd1, 6'd0, 1'b0, 1'b1, 1'b0, "R5 overflow before shifts");
    drive(4'd4, 32'h8000_0000, 32'd0, 6'd40, 1'b1, 1'b1, 1'b0, "R8 asr clamp sign fill");
    drive(4'd4, 32'h8000_00F0, 32'd0, 6'd4, 1'b1, 1'b1, 1'b0, "R8 asr by 4");
    drive(4'd4, 32'h7000_0000, 32'd0, 6'd32, 1'b1, 1'b1, 1'b0, "R8 asr by 32 positive");
    drive(4'd5, 32'hFFFF_FFFF, 32'd0, 6'd63, 1'b1, 1'b1, 1'b0, "R8 lsr clamp");
    drive(4'd5, 32'h8000_0000, 32'd0, 6'd31, 1'b1, 1'b1, 1'b0, "R8 lsr by 31");
    drive(4'd6, 32'hFFFF_FFFF, 32'd0, 6'd33, 1'b1, 1'b1, 1'b0, "R8 lsl clamp");
    drive(4'd6, 32'h0000_000F, 32'd0, 6'd4, 1'b1, 1'b1, 1'b0, "R8 lsl by 4");
    drive(4'd0, 32'd0, 32'd0, 6'd0, 1'b0, 1'b0, 1'b1, "R6 clear before add-shift");
    drive(4'd7, 32'h1000_0000, 32'h1000_0000, 6'd1, 1'b1, 1'b1, 1'b0, "R9 add-shift 1 no overflow");
    drive(4'd7, 32'h2000_0000, 32'h2000_0000, 6'd0, 1'b1, 1'b1, 1'b0, "R9 add-shift 0 no check");
    drive(4'd7, 32'h1000_0000, 32'h1000_0000, 6'd2, 1'b1, 1'b1, 1'b0, "R9 add-shift second step overflow");
    drive(4'd0, 32'd0, 32'd0, 6'd0, 1'b0, 1'b0, 1'b1, "R6 clear again");
    drive(4'd7, 32'h3000_0000, 32'h3000_0000, 6'd1, 1'b1, 1'b1, 1'b0, "R9 add-shift first step overflow");
    drive(4'd7, 32'h0000_0001, 32'h0000_0002, 6'd3, 1'b1, 1'b1, 1'b0, "R9 count 3 acts as 2");
    drive(4'd7, 32'h1000_0000, 32'h1000_0000, 6'd7, 1'b1, 1'b1, 1'b0, "R9 count 7 acts as 2");
    drive(4'd0, 32'h8000_0000, 32'h8000_0000, 6'd0, 1'b1, 1'b1, 1'b0, "R2 add negative overflow carry");
    drive(4'd9, 32'h1234_5678, 32'h1, 6'd0, 1'b1, 1'b1, 1'b0, "R11 unused code");
    drive(4'd15, 32'h0, 32'h0, 6'd0, 1'b0, 1'b1, 1'b0, "R11 unused code 15");

    @(negedge clk);
    opValid = 1'b0; stickyClr = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule